// File: doc/BRIEF.md
# Packed Uniform Vector Write Unpacker

This block gathers a stream of 32-bit data writes into four-component shader constant vectors and stores each finished vector in a uniform memory. The memory has 96 entries, and each entry holds four 24-bit floating-point components. A setup port loads the destination entry number and the input format. The block then takes data words one at a time on a single valid strobe.

There are two input formats. In packed mode, three words carry all four 24-bit components back to back. In single-precision mode, four IEEE-754 words arrive one at a time. Each of these words is narrowed to the 24-bit format, and the words land in the vector from the top component down. When a vector completes, the block stores it and moves the destination entry forward by one, so a run of vectors fills a run of entries. If a vector completes while the destination is past the end of the memory, the block drops it and pulses an error output.

An entry is laid out as {w, z, y, x}: w sits in bits [95:72], z in [71:48], y in [47:24] and x in [23:0]. The 24-bit format has a sign in bit 23, a 7-bit exponent with bias 63 in bits [22:16], and a 16-bit fraction in bits [15:0].

Top module: `uniform_unpacker`

## Requirements
- R1: After reset the destination entry is 0, the mode is packed, no partial vector is held and `err_pulse` is low.
- R2: In packed mode (`setup_f32`=0) the third data word completes a vector. The stored entry equals the 96-bit concatenation {first word, second word, third word}. This puts w = word0[31:8], z = {word0[7:0], word1[31:16]}, y = {word1[15:0], word2[31:24]} and x = word2[23:0].
- R3: In single-precision mode (`setup_f32`=1) the fourth data word completes a vector. The first word goes to w, the second to z, the third to y and the fourth to x.
- R4: A single-precision word whose biased exponent e is in 65..190 converts to {sign, e-64 as 7 bits, fraction bits [22:7]}. The lower 7 fraction bits are dropped.
- R5: A single-precision word with e of 64 or less (zero, denormals and underflow) converts to signed zero: {sign, 23'b0}.
- R6: A single-precision word with e of 191 or more (overflow, infinity, NaN) converts to signed infinity: {sign, 7'h7F, 16'h0}.
- R7: Storing a vector raises the destination entry by one, so vectors written back to back fill entries in sequence. The memory write and the increment take effect at the clock edge that accepts the completing word.
- R8: A vector that completes while the destination entry is 96 or more is not stored, and the destination stays unchanged. `err_pulse` is high for exactly the one cycle after the completing word.
- R9: A setup write loads the destination and mode, and discards any partially received vector. If a setup write and a data write arrive in the same cycle, the data word is dropped.
- R10: The word count advances only on cycles with `wr_valid` high, so idle cycles between the words of a vector change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One data word is present this cycle |
| wr_data | input | 32 | Data word |
| setup_valid | input | 1 | Load destination and mode this cycle |
| setup_f32 | input | 1 | Mode loaded by setup: 1 single precision, 0 packed |
| setup_index | input | 7 | Destination entry loaded by setup |
| rd_index | input | 7 | Read port entry select; entries 96 and above read as zero |
| rd_data | output | 96 | Combinational read of the selected entry, {w,z,y,x} |
| cur_index | output | 7 | Current destination entry |
| err_pulse | output | 1 | One-cycle pulse when a vector targets an entry out of range |

## Verification
Some properties are checked on every cycle. The word count must stay below three in packed mode. Every memory write must target an entry below 96 and be followed by a destination increment of exactly one. An error pulse must last one cycle and leave the destination unchanged. A setup write must clear the partial vector and load the new destination. Idle cycles must freeze both the count and the destination.

Other behaviour shows up only in the directed scenarios, because it concerns the values that land in memory. These scenarios cover the bit layout of packed vectors and the reversed slot order of single-precision vectors. They also cover the exponent boundaries of the narrowing conversion, that a dropped vector leaves the last valid entry untouched, and that a word arriving with a setup write is lost.

// File: rtl/uu_pkg.sv
package uu_pkg;
    parameter int WORD_W = 32;
    parameter int COMP_W = 24;
    parameter int COMPS  = 4;
    localparam int VEC_W      = COMPS * COMP_W;
    localparam int PACK_WORDS = VEC_W / WORD_W;
    localparam int STG_WORDS  = COMPS - 1;
    localparam int CNT_W      = $clog2(COMPS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [COMP_W-1:0] comp_t;
    typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/uu_f32_to_f24.sv
module uu_f32_to_f24 #(
    parameter int IN_EXP  = 8,
    parameter int IN_MAN  = 23,
    parameter int OUT_EXP = 7,
    parameter int OUT_MAN = 16
) (
    input  logic [IN_EXP+IN_MAN:0]   f_in,
    output logic [OUT_EXP+OUT_MAN:0] f_out
);
    localparam int IN_BIAS  = (1 << (IN_EXP - 1)) - 1;
    localparam int OUT_BIAS = (1 << (OUT_EXP - 1)) - 1;
    localparam int OFS      = IN_BIAS - OUT_BIAS;
    localparam logic [IN_EXP-1:0] EXP_LO  = IN_EXP'(OFS);
    localparam logic [IN_EXP-1:0] EXP_HI  = IN_EXP'(OFS + (1 << OUT_EXP) - 1);
    localparam logic [IN_EXP-1:0] EXP_OFS = IN_EXP'(OFS);

    logic                sgn;
    logic [IN_EXP-1:0]   exp_in;
    logic [IN_EXP-1:0]   exp_rb;
    logic [OUT_MAN-1:0]  man_keep;
    logic                unused_low;

    assign sgn        = f_in[IN_EXP+IN_MAN];
    assign exp_in     = f_in[IN_EXP+IN_MAN-1 -: IN_EXP];
    assign exp_rb     = exp_in - EXP_OFS;
    assign man_keep   = f_in[IN_MAN-1 -: OUT_MAN];
    assign unused_low = ^{f_in[IN_MAN-OUT_MAN-1:0], exp_rb[IN_EXP-1:OUT_EXP]};

    always_comb begin
        if (exp_in <= EXP_LO) begin
            f_out = {sgn, {(OUT_EXP+OUT_MAN){1'b0}}};
        end else if (exp_in >= EXP_HI) begin
            f_out = {sgn, {OUT_EXP{1'b1}}, {OUT_MAN{1'b0}}};
        end else begin
            f_out = {sgn, exp_rb[OUT_EXP-1:0], man_keep};
        end
    end
endmodule

// File: rtl/uu_mem.sv
module uu_mem #(
    parameter int DEPTH  = 96,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 96
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = (raddr <= LAST) ? store[raddr] : '0;
endmodule

// File: rtl/uniform_unpacker.sv
module uniform_unpacker
    import uu_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             setup_valid,
    input  logic             setup_f32,
    input  logic [IDX_W-1:0] setup_index,
    input  logic [IDX_W-1:0] rd_index,
    output logic [95:0]      rd_data,
    output logic [IDX_W-1:0] cur_index,
    output logic             err_pulse
);
    localparam logic [CNT_W-1:0] F32_LAST  = CNT_W'(COMPS - 1);
    localparam logic [CNT_W-1:0] PACK_LAST = CNT_W'(PACK_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        word_t [STG_WORDS-1:0]       stage;
        logic                        f32;
        logic [IDX_W-1:0]            idx;
        logic                        err;
    } state_t;

    state_t s_d, s_q;

    word_t            cvt_in  [COMPS];
    comp_t            cvt_out [COMPS];
    vec_t             vec_f32;
    vec_t             vec_pack;
    logic             mem_we;
    vec_t             mem_wdata;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] cnt_q;

    // converter bank: staged words first, the arriving word last
    for (genvar g = 0; g < COMPS; g++) begin : g_cvt
        if (g < STG_WORDS) begin : g_stg
            assign cvt_in[g] = s_q.stage[g];
        end else begin : g_live
            assign cvt_in[g] = wr_data;
        end
        uu_f32_to_f24 u_cvt (
            .f_in  (cvt_in[g]),
            .f_out (cvt_out[g])
        );
        // earliest word lands in the highest component slot
        assign vec_f32[VEC_W-1-g*COMP_W -: COMP_W] = cvt_out[g];
    end

    assign vec_pack = {s_q.stage[0], s_q.stage[1], wr_data};
    assign last_cnt = s_q.f32 ? F32_LAST : PACK_LAST;

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = s_q.f32 ? vec_f32 : vec_pack;
        if (setup_valid) begin
            s_d.idx = setup_index;
            s_d.f32 = setup_f32;
            s_d.cnt = '0;
        end else if (wr_valid) begin
            if (s_q.cnt == last_cnt) begin
                s_d.cnt = '0;
                if (s_q.idx <= IDX_LAST) begin
                    mem_we  = 1'b1;
                    s_d.idx = s_q.idx + 1'b1;
                end else begin
                    s_d.err = 1'b1;
                end
            end else begin
                for (int k = 0; k < STG_WORDS; k++) begin
                    if (s_q.cnt == CNT_W'(k)) begin
                        s_d.stage[k] = wr_data;
                    end
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    uu_mem #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .DATA_W (VEC_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (s_q.idx),
        .wdata (mem_wdata),
        .raddr (rd_index),
        .rdata (rd_data)
    );

    assign cnt_q     = s_q.cnt;
    assign cur_index = s_q.idx;
    assign err_pulse = s_q.err;
endmodule

// File: rtl/uu_checker.sv
module uu_checker #(
    parameter int DEPTH = 96,
    parameter int IDX_W = 7,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             setup_valid,
    input logic             setup_f32,
    input logic [IDX_W-1:0] setup_index,
    input logic [CNT_W-1:0] cnt,
    input logic [IDX_W-1:0] idx,
    input logic             err_pulse,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_waddr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic mode_f32;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_f32 <= 1'b0;
        else if (setup_valid) mode_f32 <= setup_f32;
    end

    assert_pack_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_f32 |-> cnt != CNT_W'(3));

    assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> idx == IDX_W'($past(idx) + 1'b1));

    assert_store_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_waddr <= LAST);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> idx == $past(idx));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    assert_setup_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> (cnt == '0) && (idx == $past(setup_index)));

    assert_idle_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !setup_valid) |=> $stable(cnt) && $stable(idx));
endmodule

bind uniform_unpacker uu_checker #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .CNT_W (uu_pkg::CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .setup_valid (setup_valid),
    .setup_f32   (setup_f32),
    .setup_index (setup_index),
    .cnt         (cnt_q),
    .idx         (cur_index),
    .err_pulse   (err_pulse),
    .mem_we      (mem_we),
    .mem_waddr   (cur_index)
);

// File: tb/sim_uniform_unpacker.sv
`timescale 1ns/1ps
module sim_uniform_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        setup_valid = 1'b0;
    logic        setup_f32 = 1'b0;
    logic [6:0]  setup_index = '0;
    logic [6:0]  rd_index = '0;
    logic [95:0] rd_data;
    logic [6:0]  cur_index;
    logic        err_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uniform_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .setup_valid(setup_valid), .setup_f32(setup_f32), .setup_index(setup_index),
        .rd_index(rd_index), .rd_data(rd_data), .cur_index(cur_index), .err_pulse(err_pulse)
    );

    task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic setup(input logic [6:0] i, input logic f);
        setup_valid = 1'b1; setup_index = i; setup_f32 = f;
        @(posedge clk); #1;
        setup_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic entry(input logic [6:0] i, output logic [95:0] v);
        rd_index = i; #1; v = rd_data;
    endtask

    task automatic t_reset;
        chk("R1 index", 96'(cur_index), 96'd0);
        chk("R1 err", 96'(err_pulse), 96'd0);
    endtask

    task automatic t_packed;
        logic [95:0] v;
        // no setup: default packed mode at entry 0 (R1, R2)
        wr(32'h11223344); wr(32'h55667788);
        chk("R2 not yet complete", 96'(cur_index), 96'd0);
        wr(32'h99AABBCC);
        entry(7'd0, v);
        chk("R2 layout", v, 96'h112233_445566_778899_AABBCC);
        chk("R7 index after packed", 96'(cur_index), 96'd1);
    endtask

    task automatic t_f32;
        logic [95:0] v;
        setup(7'd10, 1'b1);
        wr(32'h3F800000); wr(32'h40000000); wr(32'hBFC00000);
        chk("R3 waits for fourth word", 96'(cur_index), 96'd10);
        wr(32'h3F000000);
        entry(7'd10, v);
        chk("R3 R4 reversed order", v, 96'h3F0000_400000_BF8000_3E0000);
        chk("R7 index after f32", 96'(cur_index), 96'd11);
    endtask

    task automatic t_edges;
        logic [95:0] v;
        setup(7'd20, 1'b1);
        wr(32'h00000000); wr(32'h80000000); wr(32'h20000000); wr(32'h20800000);
        entry(7'd20, v);
        chk("R5 zero and underflow, R4 lowest exp", v, 96'h000000_800000_000000_010000);
        wr(32'h7F800000); wr(32'hFF7FFFFF); wr(32'h5F800000); wr(32'h5F7FFFFF);
        entry(7'd21, v);
        chk("R6 overflow, R4 highest exp", v, 96'h7F0000_FF0000_7F0000_7EFFFF);
    endtask

    task automatic t_seq;
        logic [95:0] v;
        setup(7'd40, 1'b0);
        wr(32'hA1A2A3A4); wr(32'hA5A6A7A8); wr(32'hA9AAABAC);
        wr(32'hB1B2B3B4); wr(32'hB5B6B7B8); wr(32'hB9BABBBC);
        entry(7'd40, v);
        chk("R7 first entry", v, 96'hA1A2A3A4_A5A6A7A8_A9AAABAC);
        entry(7'd41, v);
        chk("R7 second entry", v, 96'hB1B2B3B4_B5B6B7B8_B9BABBBC);
        chk("R7 index after two", 96'(cur_index), 96'd42);
    endtask

    task automatic t_range;
        logic [95:0] v;
        setup(7'd95, 1'b0);
        wr(32'h01010101); wr(32'h02020202); wr(32'h03030303);
        chk("R7 index past last", 96'(cur_index), 96'd96);
        chk("R8 no err on last entry", 96'(err_pulse), 96'd0);
        wr(32'hEEEEEEEE); wr(32'hDDDDDDDD); wr(32'hCCCCCCCC);
        chk("R8 err pulse", 96'(err_pulse), 96'd1);
        chk("R8 index held", 96'(cur_index), 96'd96);
        idle(1);
        chk("R8 err one cycle", 96'(err_pulse), 96'd0);
        entry(7'd95, v);
        chk("R8 last entry untouched", v, 96'h01010101_02020202_03030303);
        setup(7'd100, 1'b1);
        wr(32'h3F800000); wr(32'h3F800000); wr(32'h3F800000); wr(32'h3F800000);
        chk("R8 err f32 mode", 96'(err_pulse), 96'd1);
        chk("R8 index held f32", 96'(cur_index), 96'd100);
    endtask

    task automatic t_abort;
        logic [95:0] v;
        setup(7'd50, 1'b1);
        wr(32'h12345678); wr(32'h9ABCDEF0);
        setup(7'd50, 1'b0);
        wr(32'h0000AAAA); wr(32'h0000BBBB); wr(32'h0000CCCC);
        entry(7'd50, v);
        chk("R9 partial discarded", v, 96'h0000AAAA_0000BBBB_0000CCCC);
        chk("R9 index", 96'(cur_index), 96'd51);
        // setup and data in the same cycle: word is dropped
        setup_valid = 1'b1; setup_index = 7'd60; setup_f32 = 1'b0;
        wr_valid = 1'b1; wr_data = 32'hFFFFFFFF;
        @(posedge clk); #1;
        setup_valid = 1'b0; wr_valid = 1'b0;
        wr(32'h11111111); wr(32'h22222222);
        chk("R9 dropped word not counted", 96'(cur_index), 96'd60);
        wr(32'h33333333);
        entry(7'd60, v);
        chk("R9 collision entry", v, 96'h11111111_22222222_33333333);
    endtask

    task automatic t_gap;
        logic [95:0] v;
        setup(7'd70, 1'b0);
        wr(32'hCAFE0001);
        idle(5);
        wr(32'hCAFE0002);
        idle(3);
        chk("R10 idle holds", 96'(cur_index), 96'd70);
        wr(32'hCAFE0003);
        entry(7'd70, v);
        chk("R10 gapped entry", v, 96'hCAFE0001_CAFE0002_CAFE0003);
        chk("R10 index", 96'(cur_index), 96'd71);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_packed();
        t_f32();
        t_edges();
        t_seq();
        t_range();
        t_abort();
        t_gap();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule